// File: doc/BRIEF.md
# Partitioned Packed-Lane Arithmetic Unit

This unit treats each 64-bit operand as a short vector of equal lanes and applies one arithmetic, averaging, shift-and-accumulate, comparison or high-half multiply operation to every lane in the same cycle. The lane size can be 8, 16 or 32 bits. No carry, borrow or comparison result ever passes from one lane to its neighbour. It is meant to sit in an execution stage next to a scalar integer unit, so that one 64-bit register can carry eight, four or two small values.

Each cycle the caller presents two operands, an operation code, a lane-size code, a shift count and an overflow policy. The lane-wise result appears on the output one clock later. Wraparound and two kinds of clamping are available for addition and subtraction. Shift-and-accumulate always clamps to the signed lane range.

Top module: `pack_alu`

## Requirements
- R1: The lane-size code `lane_sel` picks 0 = 8-bit lanes, 1 = 16-bit lanes, 2 = 32-bit lanes. Lane i occupies bits [i*W +: W]. No carry or borrow crosses a lane boundary. Code 3 yields an all-zero result.
- R2: Operation code 0 adds per lane. `ovf_mode` selects the overflow policy: 0 = wraparound, 1 = clamp to the signed lane range, 2 = clamp to the unsigned lane range, 3 = wraparound.
- R3: Operation code 1 subtracts `src_b` from `src_a` per lane. It uses the same `ovf_mode` policies as R2, and unsigned clamping floors at zero.
- R4: Operation code 2 returns the unsigned mean (a+b+1)>>1 of each lane, rounded up, computed without loss of the carry. `ovf_mode` has no effect on it.
- R5: Operation code 3 returns (a << `shamt`) + b per lane, with operands signed. `shamt` may be 0 to 3. The result is clamped to the signed lane range.
- R6: Operation code 4 (equal) and code 5 (signed greater-than) set every bit of a lane when the condition holds and clear every bit otherwise.
- R7: Operation code 6 forms the signed product of each 16-bit lane and returns product bits [31:16]. With any other lane size it returns zero.
- R8: Operation code 7 is reserved and yields an all-zero result.
- R9: The result is registered, so it appears on the first rising clock edge after the inputs. A synchronous active-low reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| op_code | input | 3 | Operation selector (R2-R8) |
| lane_sel | input | 2 | Lane size selector (R1) |
| shamt | input | 2 | Shift count for shift-and-accumulate |
| ovf_mode | input | 2 | Overflow policy for add and subtract |
| result | output | 64 | Registered lane-wise result |

## Verification
The hardest case to reach is a carry or borrow that would leak into the next lane while that next lane must come out unchanged. Stimulus reaches it through operands in which one lane wraps exactly at its boundary (FF+01, 0-1 across a 32-bit seam) beside lanes whose correct values are small and known. Every clamp direction is driven the same way: the signed maximum, the signed minimum and the unsigned ceiling and floor each sit in a separate lane of one word. Shift-and-accumulate is pushed past both signed limits with the largest count.

// File: rtl/pack_alu_pkg.sv
// Shared encodings for the packed-lane arithmetic unit.
// Assumes a 64-bit datapath; the lane widths are chosen by the top module.
package pack_alu_pkg;
    localparam int unsigned WORD_W = 64;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_AVG    = 3'd2,
        OP_SHLADD = 3'd3,
        OP_CMPEQ  = 3'd4,
        OP_CMPGT  = 3'd5,
        OP_MULHI  = 3'd6,
        OP_RSVD   = 3'd7
    } pack_op_e;

    typedef enum logic [1:0] {
        LANE_NARROW = 2'd0,
        LANE_MID    = 2'd1,
        LANE_WIDE   = 2'd2,
        LANE_NONE   = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        OVF_WRAP  = 2'd0,
        OVF_SSAT  = 2'd1,
        OVF_USAT  = 2'd2,
        OVF_WRAP2 = 2'd3
    } ovf_mode_e;
endpackage

// File: rtl/pack_lane.sv
// One lane of width W: computes every lane operation and selects one.
// Assumes W >= 4. The multiplier exists only when HAS_MUL is set;
// otherwise the high-half multiply returns zero.
module pack_lane
    import pack_alu_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter bit          HAS_MUL = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  pack_op_e     op,
    input  ovf_mode_e    mode,
    input  logic [1:0]   shamt,
    output logic [W-1:0] y
);
    localparam int unsigned XW = W + 4;

    logic [W-1:0]  smax, smin, umax;
    logic [W:0]    sum_s, sum_u, dif_s, dif_u, avg_x;
    logic [XW-1:0] a_ext, b_ext, sh_sum;
    logic [W-1:0]  add_r, sub_r, shl_r, mul_hi;
    logic          sh_ovf;

    assign smax = {1'b0, {(W-1){1'b1}}};
    assign smin = {1'b1, {(W-1){1'b0}}};
    assign umax = {W{1'b1}};

    // Widened sums and differences keep carry, borrow and sign information.
    always_comb begin
        sum_s = {a[W-1], a} + {b[W-1], b};
        sum_u = {1'b0, a} + {1'b0, b};
        dif_s = {a[W-1], a} - {b[W-1], b};
        dif_u = {1'b0, a} - {1'b0, b};
        avg_x = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
    end

    // Add under the selected overflow policy.
    always_comb begin
        unique case (mode)
            OVF_SSAT: add_r = (sum_s[W] != sum_s[W-1]) ? (sum_s[W] ? smin : smax) : sum_s[W-1:0];
            OVF_USAT: add_r = sum_u[W] ? umax : sum_u[W-1:0];
            default:  add_r = sum_u[W-1:0];
        endcase
    end

    // Subtract under the selected overflow policy.
    always_comb begin
        unique case (mode)
            OVF_SSAT: sub_r = (dif_s[W] != dif_s[W-1]) ? (dif_s[W] ? smin : smax) : dif_s[W-1:0];
            OVF_USAT: sub_r = dif_u[W] ? '0 : dif_u[W-1:0];
            default:  sub_r = dif_u[W-1:0];
        endcase
    end

    // Shift-and-accumulate in a widened signed domain, then clamp.
    always_comb begin
        a_ext  = {{4{a[W-1]}}, a};
        b_ext  = {{4{b[W-1]}}, b};
        sh_sum = (a_ext << shamt) + b_ext;
        sh_ovf = !((&sh_sum[XW-1:W-1]) || (~|sh_sum[XW-1:W-1]));
        shl_r  = sh_ovf ? (sh_sum[XW-1] ? smin : smax) : sh_sum[W-1:0];
    end

    // Multiplier present only in lanes of the multiply width.
    generate
        if (HAS_MUL) begin : g_mul
            logic signed [2*W-1:0] prod;
            assign prod   = $signed(a) * $signed(b);
            assign mul_hi = prod[2*W-1:W];
        end else begin : g_nomul
            assign mul_hi = '0;
        end
    endgenerate

    // Final operation select.
    always_comb begin
        unique case (op)
            OP_ADD:    y = add_r;
            OP_SUB:    y = sub_r;
            OP_AVG:    y = avg_x[W:1];
            OP_SHLADD: y = shl_r;
            OP_CMPEQ:  y = (a == b) ? umax : '0;
            OP_CMPGT:  y = ($signed(a) > $signed(b)) ? umax : '0;
            OP_MULHI:  y = mul_hi;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/pack_lane_array.sv
// Splits a word into WORD_W/LANE_W independent lanes of one fixed size.
// Assumes LANE_W divides WORD_W exactly.
module pack_lane_array
    import pack_alu_pkg::*;
#(
    parameter int unsigned WORD_BITS = 64,
    parameter int unsigned LANE_W    = 8,
    parameter bit          HAS_MUL   = 1'b0
) (
    input  logic [WORD_BITS-1:0] a,
    input  logic [WORD_BITS-1:0] b,
    input  pack_op_e             op,
    input  ovf_mode_e            mode,
    input  logic [1:0]           shamt,
    output logic [WORD_BITS-1:0] y
);
    localparam int unsigned N_LANES = WORD_BITS / LANE_W;

    // One lane instance per slice; no signal links adjacent slices.
    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            pack_lane #(.W(LANE_W), .HAS_MUL(HAS_MUL)) u_lane (
                .a    (a[g*LANE_W +: LANE_W]),
                .b    (b[g*LANE_W +: LANE_W]),
                .op   (op),
                .mode (mode),
                .shamt(shamt),
                .y    (y[g*LANE_W +: LANE_W])
            );
        end
    endgenerate
endmodule

// File: rtl/pack_alu.sv
// Top of the packed-lane unit: three lane arrays run in parallel, the
// lane-size code selects one, and the choice is registered.
// Assumes synchronous active-low reset; one cycle of latency.
module pack_alu
    import pack_alu_pkg::*;
#(
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned MID_W    = 16,
    parameter int unsigned WIDE_W   = 32,
    parameter int unsigned MUL_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   src_a,
    input  logic [WORD_W-1:0]   src_b,
    input  logic [2:0]          op_code,
    input  logic [1:0]          lane_sel,
    input  logic [1:0]          shamt,
    input  logic [1:0]          ovf_mode,
    output logic [WORD_W-1:0]   result
);
    pack_op_e    op;
    ovf_mode_e   mode;
    lane_sz_e    lsz;
    logic [WORD_W-1:0] y_narrow, y_mid, y_wide, y_sel;

    assign op   = pack_op_e'(op_code);
    assign mode = ovf_mode_e'(ovf_mode);
    assign lsz  = lane_sz_e'(lane_sel);

    pack_lane_array #(.WORD_BITS(WORD_W), .LANE_W(NARROW_W), .HAS_MUL(NARROW_W == MUL_W)) u_narrow (
        .a(src_a), .b(src_b), .op(op), .mode(mode), .shamt(shamt), .y(y_narrow));
    pack_lane_array #(.WORD_BITS(WORD_W), .LANE_W(MID_W), .HAS_MUL(MID_W == MUL_W)) u_mid (
        .a(src_a), .b(src_b), .op(op), .mode(mode), .shamt(shamt), .y(y_mid));
    pack_lane_array #(.WORD_BITS(WORD_W), .LANE_W(WIDE_W), .HAS_MUL(WIDE_W == MUL_W)) u_wide (
        .a(src_a), .b(src_b), .op(op), .mode(mode), .shamt(shamt), .y(y_wide));

    // Pick the array matching the requested lane size.
    always_comb begin
        unique case (lsz)
            LANE_NARROW: y_sel = y_narrow;
            LANE_MID:    y_sel = y_mid;
            LANE_WIDE:   y_sel = y_wide;
            default:     y_sel = '0;
        endcase
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= y_sel;
    end
endmodule

// File: rtl/pack_alu_chk.sv
// Temporal checks on the packed-lane unit, attached through bind.
// Assumes the one-cycle latency of the top module.
module pack_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic [2:0]  op_code,
    input logic [1:0]  lane_sel,
    input logic [1:0]  ovf_mode,
    input logic [63:0] result
);
    logic past_ok;

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6
    cmp_equal_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_code == 3'd4 && src_a == src_b && lane_sel != 2'd3) |-> result == '1);

    // R7
    mulhi_other_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_code == 3'd6 && lane_sel != 2'd1) |-> result == '0);

    // R8
    reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_code == 3'd7) |-> result == '0);

    // R1
    no_lane_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(lane_sel == 2'd3) |-> result == '0);

    generate
        for (genvar g = 0; g < 8; g++) begin : g_byte
            // R6
            cmp_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok && $past(op_code == 3'd4 || op_code == 3'd5)
                |-> (result[g*8 +: 8] == 8'h00 || result[g*8 +: 8] == 8'hFF));
            // R2
            usat_add_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok && $past(op_code == 3'd0 && ovf_mode == 2'd2 && lane_sel == 2'd0)
                |-> result[g*8 +: 8] >= $past(src_a[g*8 +: 8]));
            // R3
            usat_sub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok && $past(op_code == 3'd1 && ovf_mode == 2'd2 && lane_sel == 2'd0)
                |-> result[g*8 +: 8] <= $past(src_a[g*8 +: 8]));
        end
    endgenerate
endmodule

bind pack_alu pack_alu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_a   (src_a),
    .src_b   (src_b),
    .op_code (op_code),
    .lane_sel(lane_sel),
    .ovf_mode(ovf_mode),
    .result  (result)
);

// File: tb/tb_pack_alu.sv
`timescale 1ns/1ps
module tb_pack_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [2:0]  op_code = '0;
    logic [1:0]  lane_sel = '0, shamt = '0, ovf_mode = '0;
    logic [63:0] result;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pack_alu dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .op_code(op_code),
        .lane_sel(lane_sel), .shamt(shamt), .ovf_mode(ovf_mode), .result(result));

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  lsz;
        logic [1:0]  sh;
        logic [1:0]  ovf;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R2 wrap, 8-bit: FF+01 wraps and does not disturb its neighbour (R1)
        '{3'd0, 2'd0, 2'd0, 2'd0, 64'h0102_0304_05FF_7F80, 64'h0101_0101_0101_0101, 64'h0203_0405_0600_8081, 4'd2},
        // R2 signed clamp, 8-bit
        '{3'd0, 2'd0, 2'd0, 2'd1, 64'h0102_0304_05FF_7F80, 64'h0101_0101_0101_0101, 64'h0203_0405_0600_7F81, 4'd2},
        // R2 unsigned clamp, 8-bit
        '{3'd0, 2'd0, 2'd0, 2'd2, 64'h0102_0304_05FF_7F80, 64'h0101_0101_0101_0101, 64'h0203_0405_06FF_8081, 4'd2},
        // R2 unsigned clamp, 16-bit
        '{3'd0, 2'd1, 2'd0, 2'd2, 64'hFFFF_0001_8000_1234, 64'h0001_FFFF_8000_0001, 64'hFFFF_FFFF_FFFF_1235, 4'd2},
        // R2 wrap mode 3, 16-bit
        '{3'd0, 2'd1, 2'd0, 2'd3, 64'hFFFF_0001_8000_1234, 64'h0001_FFFF_8000_0001, 64'h0000_0000_0000_1235, 4'd2},
        // R2 signed clamp, 32-bit, both limits
        '{3'd0, 2'd2, 2'd0, 2'd1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 64'h7FFF_FFFF_8000_0000, 4'd2},
        // R3 unsigned floor, 16-bit
        '{3'd1, 2'd1, 2'd0, 2'd2, 64'h0005_0010_8000_FFFF, 64'h0006_0001_0001_FFFF, 64'h0000_000F_7FFF_0000, 4'd3},
        // R3 signed clamp, 16-bit
        '{3'd1, 2'd1, 2'd0, 2'd1, 64'h0005_0010_8000_FFFF, 64'h0006_0001_0001_FFFF, 64'hFFFF_000F_8000_0000, 4'd3},
        // R1 borrow blocked at the 32-bit seam (R3 wrap)
        '{3'd1, 2'd2, 2'd0, 2'd0, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF, 4'd1},
        // R4 average, 8-bit, clamp mode set but ignored
        '{3'd2, 2'd0, 2'd0, 2'd2, 64'hFF00_0102_FE7F_0003, 64'hFF01_0001_FF80_0000, 64'hFF01_0102_FF80_0002, 4'd4},
        // R4 average, 32-bit
        '{3'd2, 2'd2, 2'd0, 2'd0, 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_0000_0002, 64'hFFFF_FFFF_0000_0002, 4'd4},
        // R5 shift 2, 16-bit, positive clamp and negative in range
        '{3'd3, 2'd1, 2'd2, 2'd0, 64'h0001_1000_F000_2000, 64'h0003_0000_0000_1000, 64'h0007_4000_C000_7FFF, 4'd5},
        // R5 shift 3, 8-bit, both clamps
        '{3'd3, 2'd0, 2'd3, 2'd0, 64'h10F0_01E0_0000_0000, 64'h0000_0500_0000_0000, 64'h7F80_0D80_0000_0000, 4'd5},
        // R6 equal, 8-bit
        '{3'd4, 2'd0, 2'd0, 2'd0, 64'h0011_2233_4455_6677, 64'h0011_2200_4455_0077, 64'hFFFF_FF00_FFFF_00FF, 4'd6},
        // R6 signed greater, 16-bit
        '{3'd5, 2'd1, 2'd0, 2'd0, 64'h0001_8000_7FFF_0000, 64'h0000_0001_8000_0000, 64'hFFFF_0000_FFFF_0000, 4'd6},
        // R6 signed greater, 32-bit
        '{3'd5, 2'd2, 2'd0, 2'd0, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 4'd6},
        // R7 high-half multiply, 16-bit
        '{3'd6, 2'd1, 2'd0, 2'd0, 64'h7FFF_8000_0100_FFFF, 64'h7FFF_8000_0100_0002, 64'h3FFF_4000_0001_FFFF, 4'd7},
        // R7 multiply with 8-bit lanes gives zero
        '{3'd6, 2'd0, 2'd0, 2'd0, 64'h7FFF_8000_0100_FFFF, 64'h7FFF_8000_0100_0002, 64'h0000_0000_0000_0000, 4'd7},
        // R8 reserved op gives zero
        '{3'd7, 2'd1, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000, 4'd8}
    };

    task automatic check(input logic [63:0] exp, input int req, input string what);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, result, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [1:0] lsz, input logic [1:0] sh,
                         input logic [1:0] ovf, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op_code = op; lane_sel = lsz; shamt = sh; ovf_mode = ovf; src_a = a; src_b = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(64'h0, 9, "reset state");   // R9
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].lsz, VECS[i].sh, VECS[i].ovf, VECS[i].a, VECS[i].b);
            check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R1: lane code 3 yields zero
        apply(3'd0, 2'd3, 2'd0, 2'd0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101);
        check(64'h0, 1, "lane code 3");

        // R5: shift count 0 is a signed clamped add
        apply(3'd3, 2'd0, 2'd0, 2'd0, 64'h0000_0000_0000_207F, 64'h0000_0000_0000_0101);
        check(64'h0000_0000_0000_217F, 5, "shift count 0");

        // R9: result follows inputs after exactly one edge
        @(negedge clk);
        op_code = 3'd0; lane_sel = 2'd0; ovf_mode = 2'd0;
        src_a = 64'h0000_0000_0000_0001; src_b = 64'h0000_0000_0000_0001;
        check(64'h0000_0000_0000_217F, 9, "holds before edge");
        @(negedge clk);
        check(64'h0000_0000_0000_0002, 9, "one-cycle latency");

        // R9: synchronous reset clears a non-zero result
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(64'h0, 9, "reset clears");
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule